// File: doc/BRIEF.md
# CAM Host Bus Cycle Decoder

This block is the host-facing front end of a content-addressable memory. A 16-bit bidirectional bus is qualified by an active-low enable, a command/data select and an active-low write strobe. Each enabled clock cycle is decoded into one of four cycle types. The bus word is then steered into the proper internal register, or the proper register is driven back out with the output enable asserted. The match array, priority logic and segment counters are outside the block and see only the register values and the single-cycle strobes it produces.

Where a word goes depends on the cycles before it. A temporary-target instruction redirects exactly one following command cycle. An instruction carrying the address flag sends the next command write to the address register. Back-to-back status reads step from the low half to the high half. Persistent source and destination selections steer every data cycle until they are changed. A page versus device-select comparison gates the whole device, and an all-ones device select gives write-only broadcast access.

Top module: `cam_host_if`

## Requirements
- R1: Cycle decode: with `en_ni` low, `cd_i`=0/`wr_ni`=0 is a command write, `cd_i`=0/`wr_ni`=1 a command read, `cd_i`=1/`wr_ni`=0 a data write and `cd_i`=1/`wr_ni`=1 a data read. With `en_ni` high, `data_oe_o`, `instr_stb_o`, `mem_wr_o` and `mem_rd_o` are all low and no register changes.
- R2: With no redirection pending, a command write is an instruction load and `instr_stb_o` is high in that cycle. Instruction fields: bit 11 is the address flag, bits 10:8 the class (0 plain, 1 temporary target, 2 select source, 3 select destination), bits 2:0 the target code and bits 1:0 the resource code.
- R3: If the instruction loaded in the previous cycle had bit 11 set and was not of class 1, the next command write loads `addr_o` and raises no `instr_stb_o`. The flag lapses after one cycle of any kind.
- R4: A class-1 instruction redirects only the next command write or command read, skipping data and idle cycles, to the target code it carries: 0 address, 1 control, 2 page, 3 segment control, 4 device select. The cycle after that uses the default again.
- R5: Target code 5 names the next-free-address word. A redirected command read returns `nfa_i`, and a redirected command write is discarded without changing any register.
- R6: A default command read returns `status_i[15:0]`. A command read directly after a default low-half read returns `status_i[31:16]`, and the one after that returns the low half again. Any other cycle in between restores the low half.
- R7: After reset the persistent source and destination are both the comparand. A class-2 or class-3 instruction sets the source or the destination to resource code 0 comparand, 1 mask 1, 2 mask 2 or 3 memory array.
- R8: A data write loads the comparand, mask 1 or mask 2 register selected by the destination. For the memory array it raises `mem_wr_o` instead.
- R9: A data read returns the register selected by the source. For the memory array it raises `mem_rd_o` and returns `mem_rdata_i`.
- R10: A command read redirected with target code 6 returns the last class-2 instruction word, and with code 7 the last class-3 word. Both are zero after reset.
- R11: When device select differs from page and is not FFFFh, the device is deselected: reads leave `data_oe_o` low and writes are ignored. The exceptions are a class-1 instruction with target 4 and the device-select load it redirects, which always take effect.
- R12: A device select of FFFFh that differs from page accepts all writes but no reads.
- R13: `data_oe_o` is high only during a command or data read while device select equals page, and `data_o` then carries the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_ni | input | 1 | Active-low cycle enable |
| cd_i | input | 1 | 0 = command cycle, 1 = data cycle |
| wr_ni | input | 1 | Active-low write strobe |
| data_i | input | 16 | Bus word driven by host; also write data for the array |
| data_o | output | 16 | Read word (zero when not enabled) |
| data_oe_o | output | 1 | Tri-state output enable for the bus |
| status_i | input | 32 | Status word from the array side |
| nfa_i | input | 16 | Next-free-address word from the array side |
| mem_rdata_i | input | 16 | Array read data |
| instr_stb_o | output | 1 | Instruction load strobe (instruction is on data_i) |
| mem_wr_o | output | 1 | Array write strobe |
| mem_rd_o | output | 1 | Array read strobe |
| addr_o | output | 16 | Address register |
| ctrl_o | output | 16 | Control register |
| page_o | output | 16 | Page address register |
| seg_o | output | 16 | Segment control register |
| dev_sel_o | output | 16 | Device select register |
| cmp_o | output | 16 | Comparand register |
| mask1_o | output | 16 | Mask register 1 |
| mask2_o | output | 16 | Mask register 2 |

## Verification
The read word, output enable and all three strobes are combinational on the current bus cycle and the stored state, so they are due in the same cycle as the stimulus. The bench drives each cycle at the falling edge and compares these outputs one nanosecond later, before the rising edge. Register loads and all sequencing state take effect at the rising edge that ends the cycle. The bench therefore checks the register outputs at the next falling edge, before it drives the following cycle. An in-bench model steps at the same point, so redirections, flag lapses and status-half stepping are always checked against the state the model holds for that cycle.

// File: rtl/cam_bus_pkg.sv
package cam_bus_pkg;
  localparam int unsigned WORD_W        = 16;
  localparam int unsigned ADDR_FLAG_BIT = 11;
  localparam int unsigned CLS_LSB       = 8;
  localparam int unsigned CLS_W         = 3;
  localparam int unsigned TGT_W         = 3;
  localparam int unsigned RES_W         = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN = 3'd0,
    CLS_TEMP  = 3'd1,
    CLS_PSRC  = 3'd2,
    CLS_PDST  = 3'd3
  } cls_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_ADDR = 3'd0,
    TGT_CTRL = 3'd1,
    TGT_PAGE = 3'd2,
    TGT_SEG  = 3'd3,
    TGT_DSEL = 3'd4,
    TGT_NFA  = 3'd5,
    TGT_PS   = 3'd6,
    TGT_PD   = 3'd7
  } tgt_e;

  typedef enum logic [RES_W-1:0] {
    RES_CMP   = 2'd0,
    RES_MSK1  = 2'd1,
    RES_MSK2  = 2'd2,
    RES_ARRAY = 2'd3
  } res_e;

  // register bank slots; command targets 0..4 map one to one
  localparam int unsigned REG_ADDR = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_PAGE = 2;
  localparam int unsigned REG_SEG  = 3;
  localparam int unsigned REG_DSEL = 4;
  localparam int unsigned REG_CMP  = 5;
  localparam int unsigned REG_MSK1 = 6;
  localparam int unsigned REG_MSK2 = 7;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned NUM_CMD_REGS = 5;

  typedef struct packed {
    logic cmd_wr;
    logic cmd_rd;
    logic dat_wr;
    logic dat_rd;
  } cyc_t;
endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_bus_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          en_ni,
  input  logic          cd_i,
  input  logic          wr_ni,
  input  logic [DW-1:0] page_i,
  input  logic [DW-1:0] dsel_i,
  output cyc_t          cyc_o,
  output logic          rd_ok_o,
  output logic          wr_ok_o
);
  localparam logic [DW-1:0] BCAST = '1;

  logic act;

  always_comb begin
    act           = !en_ni;
    cyc_o.cmd_wr  = act && !cd_i && !wr_ni;
    cyc_o.cmd_rd  = act && !cd_i &&  wr_ni;
    cyc_o.dat_wr  = act &&  cd_i && !wr_ni;
    cyc_o.dat_rd  = act &&  cd_i &&  wr_ni;
    rd_ok_o       = (dsel_i == page_i);
    wr_ok_o       = rd_ok_o || (dsel_i == BCAST);
  end
endmodule

// File: rtl/cam_cmd_seq.sv
module cam_cmd_seq
  import cam_bus_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  cyc_t                    cyc_i,
  input  logic                    rd_ok_i,
  input  logic                    wr_ok_i,
  input  logic [DW-1:0]           data_i,
  output logic                    instr_ld_o,
  output logic [NUM_CMD_REGS-1:0] reg_we_o,
  output logic                    tco_v_o,
  output tgt_e                    tgt_o,
  output logic                    hi_o,
  output res_e                    ps_o,
  output res_e                    pd_o,
  output logic [DW-1:0]           ps_instr_o,
  output logic [DW-1:0]           pd_instr_o
);
  logic          tco_q, addr_q, hi_q;
  tgt_e          tgt_q;
  res_e          ps_q, pd_q;
  logic [DW-1:0] psi_q, pdi_q;

  cls_e in_cls;
  tgt_e in_tgt;
  res_e in_res;
  logic dsel_instr, tgt_is_reg, tgt_ld, addr_ld, lo_rd;

  always_comb begin
    in_cls     = cls_e'(data_i[CLS_LSB +: CLS_W]);
    in_tgt     = tgt_e'(data_i[TGT_W-1:0]);
    in_res     = res_e'(data_i[RES_W-1:0]);
    dsel_instr = (in_cls == CLS_TEMP) && (in_tgt == TGT_DSEL);
    tgt_is_reg = (tgt_q <= TGT_DSEL);
    // device-select path stays open while deselected
    instr_ld_o = cyc_i.cmd_wr && !tco_q && !addr_q && (wr_ok_i || dsel_instr);
    addr_ld    = cyc_i.cmd_wr && !tco_q && addr_q && wr_ok_i;
    tgt_ld     = cyc_i.cmd_wr && tco_q && tgt_is_reg &&
                 (wr_ok_i || (tgt_q == TGT_DSEL));
    lo_rd      = cyc_i.cmd_rd && rd_ok_i && !tco_q && !hi_q;
    for (int k = 0; k < NUM_CMD_REGS; k++) begin
      reg_we_o[k] = tgt_ld && (int'(tgt_q) == k);
    end
    reg_we_o[REG_ADDR] = reg_we_o[REG_ADDR] || addr_ld;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tco_q  <= 1'b0;
      tgt_q  <= TGT_ADDR;
      addr_q <= 1'b0;
      hi_q   <= 1'b0;
      ps_q   <= RES_CMP;
      pd_q   <= RES_CMP;
      psi_q  <= '0;
      pdi_q  <= '0;
    end else begin
      hi_q   <= lo_rd;
      addr_q <= instr_ld_o && data_i[ADDR_FLAG_BIT] && (in_cls != CLS_TEMP);
      if (instr_ld_o && in_cls == CLS_TEMP) begin
        tco_q <= 1'b1;
        tgt_q <= in_tgt;
      end else if (cyc_i.cmd_wr || cyc_i.cmd_rd) begin
        tco_q <= 1'b0;
      end
      if (instr_ld_o && in_cls == CLS_PSRC) begin
        ps_q  <= in_res;
        psi_q <= data_i;
      end
      if (instr_ld_o && in_cls == CLS_PDST) begin
        pd_q  <= in_res;
        pdi_q <= data_i;
      end
    end
  end

  assign tco_v_o    = tco_q;
  assign tgt_o      = tgt_q;
  assign hi_o       = hi_q;
  assign ps_o       = ps_q;
  assign pd_o       = pd_q;
  assign ps_instr_o = psi_q;
  assign pd_instr_o = pdi_q;
endmodule

// File: rtl/cam_reg_bank.sv
module cam_reg_bank
  import cam_bus_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned N  = NUM_REGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N-1:0][DW-1:0] q_o
);
  logic [DW-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[g] <= '0;
      else if (we_i[g])  q[g] <= wdata_i;
    end
    assign q_o[g] = q[g];
  end
endmodule

// File: rtl/cam_host_if.sv
module cam_host_if
  import cam_bus_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  localparam int unsigned SW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ni,
  input  logic          cd_i,
  input  logic          wr_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [SW-1:0] status_i,
  input  logic [DW-1:0] nfa_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          instr_stb_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] page_o,
  output logic [DW-1:0] seg_o,
  output logic [DW-1:0] dev_sel_o,
  output logic [DW-1:0] cmp_o,
  output logic [DW-1:0] mask1_o,
  output logic [DW-1:0] mask2_o
);
  cyc_t                        cyc;
  logic                        rd_ok, wr_ok, tco_v, hi;
  tgt_e                        tgt;
  res_e                        ps, pd;
  logic [DW-1:0]               ps_instr, pd_instr, rd_word;
  logic [NUM_CMD_REGS-1:0]     cmd_we;
  logic [NUM_REGS-1:0]         we;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  cam_cycle_decode #(.DW(DW)) u_dec (
    .en_ni   (en_ni),
    .cd_i    (cd_i),
    .wr_ni   (wr_ni),
    .page_i  (regs[REG_PAGE]),
    .dsel_i  (regs[REG_DSEL]),
    .cyc_o   (cyc),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  cam_cmd_seq #(.DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc),
    .rd_ok_i    (rd_ok),
    .wr_ok_i    (wr_ok),
    .data_i     (data_i),
    .instr_ld_o (instr_stb_o),
    .reg_we_o   (cmd_we),
    .tco_v_o    (tco_v),
    .tgt_o      (tgt),
    .hi_o       (hi),
    .ps_o       (ps),
    .pd_o       (pd),
    .ps_instr_o (ps_instr),
    .pd_instr_o (pd_instr)
  );

  // data-side write enables follow the persistent destination
  always_comb begin
    we                       = '0;
    we[NUM_CMD_REGS-1:0]     = cmd_we;
    we[REG_CMP]              = cyc.dat_wr && wr_ok && (pd == RES_CMP);
    we[REG_MSK1]             = cyc.dat_wr && wr_ok && (pd == RES_MSK1);
    we[REG_MSK2]             = cyc.dat_wr && wr_ok && (pd == RES_MSK2);
    mem_wr_o                 = cyc.dat_wr && wr_ok && (pd == RES_ARRAY);
    mem_rd_o                 = cyc.dat_rd && rd_ok && (ps == RES_ARRAY);
  end

  cam_reg_bank #(.DW(DW), .N(NUM_REGS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (data_i),
    .q_o     (regs)
  );

  always_comb begin
    rd_word = '0;
    if (cyc.cmd_rd) begin
      if (tco_v) begin
        case (tgt)
          TGT_NFA: rd_word = nfa_i;
          TGT_PS:  rd_word = ps_instr;
          TGT_PD:  rd_word = pd_instr;
          default: rd_word = regs[tgt];
        endcase
      end else begin
        rd_word = hi ? status_i[SW-1:DW] : status_i[DW-1:0];
      end
    end else if (cyc.dat_rd) begin
      case (ps)
        RES_CMP:  rd_word = regs[REG_CMP];
        RES_MSK1: rd_word = regs[REG_MSK1];
        RES_MSK2: rd_word = regs[REG_MSK2];
        default:  rd_word = mem_rdata_i;
      endcase
    end
  end

  assign data_oe_o = (cyc.cmd_rd || cyc.dat_rd) && rd_ok;
  assign data_o    = data_oe_o ? rd_word : '0;

  assign addr_o    = regs[REG_ADDR];
  assign ctrl_o    = regs[REG_CTRL];
  assign page_o    = regs[REG_PAGE];
  assign seg_o     = regs[REG_SEG];
  assign dev_sel_o = regs[REG_DSEL];
  assign cmp_o     = regs[REG_CMP];
  assign mask1_o   = regs[REG_MSK1];
  assign mask2_o   = regs[REG_MSK2];
endmodule

// File: rtl/cam_host_if_chk.sv
module cam_host_if_chk
  import cam_bus_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_ni,
  input logic          cd_i,
  input logic          wr_ni,
  input logic [DW-1:0] data_i,
  input logic          data_oe_o,
  input logic          instr_stb_o,
  input logic          mem_wr_o,
  input logic          mem_rd_o,
  input logic [DW-1:0] page_o,
  input logic [DW-1:0] dev_sel_o,
  input logic [DW-1:0] cmp_o
);
  localparam logic [DW-1:0] BCAST = '1;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> !data_oe_o && !instr_stb_o && !mem_wr_o && !mem_rd_o);

  a_r13_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !en_ni && wr_ni && (dev_sel_o == page_o));

  a_r3_flag_steals_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_stb_o && data_i[ADDR_FLAG_BIT] && data_i[CLS_LSB +: CLS_W] != 3'd1)
      |=> !instr_stb_o);

  a_r4_temp_steals_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_stb_o && data_i[CLS_LSB +: CLS_W] == 3'd1) |=> !instr_stb_o);

  a_r8_array_wr_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !en_ni && cd_i && !wr_ni);

  a_r9_array_rd_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> data_oe_o && cd_i);

  a_r11_desel_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_o != page_o && dev_sel_o != BCAST) |=> $stable(cmp_o));

  a_r12_bcast_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_o == BCAST && page_o != BCAST) |-> !data_oe_o);
endmodule

bind cam_host_if cam_host_if_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_ni       (en_ni),
  .cd_i        (cd_i),
  .wr_ni       (wr_ni),
  .data_i      (data_i),
  .data_oe_o   (data_oe_o),
  .instr_stb_o (instr_stb_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rd_o    (mem_rd_o),
  .page_o      (page_o),
  .dev_sel_o   (dev_sel_o),
  .cmp_o       (cmp_o)
);

// File: tb/cam_host_if_tb.sv
`timescale 1ns/1ps
module cam_host_if_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_ni = 1'b1, cd_i = 1'b0, wr_ni = 1'b1;
  logic [15:0] data_i = '0, nfa_i = '0, mem_rdata_i = '0;
  logic [31:0] status_i = '0;
  logic [15:0] data_o, addr_o, ctrl_o, page_o, seg_o, dev_sel_o, cmp_o, mask1_o, mask2_o;
  logic        data_oe_o, instr_stb_o, mem_wr_o, mem_rd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cam_host_if u_dut (.*);

  // reference state: 0 addr,1 ctrl,2 page,3 seg,4 dsel,5 cmp,6 mask1,7 mask2
  logic [15:0] m_reg [8];
  bit          m_tco, m_addr, m_hi;
  bit [2:0]    m_tgt;
  bit [1:0]    m_ps, m_pd;
  logic [15:0] m_psi, m_pdi;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rd_ok();
    return m_reg[4] == m_reg[2];
  endfunction
  function automatic bit wr_ok();
    return rd_ok() || m_reg[4] == 16'hFFFF;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_tco = 0; m_addr = 0; m_hi = 0; m_tgt = 0; m_ps = 0; m_pd = 0;
    m_psi = '0; m_pdi = '0;
  endtask

  task automatic chk_regs();
    chk("R3 addr",  addr_o,    m_reg[0]);
    chk("R4 ctrl",  ctrl_o,    m_reg[1]);
    chk("R11 page", page_o,    m_reg[2]);
    chk("R4 seg",   seg_o,     m_reg[3]);
    chk("R11 dsel", dev_sel_o, m_reg[4]);
    chk("R8 cmp",   cmp_o,     m_reg[5]);
    chk("R8 mask1", mask1_o,   m_reg[6]);
    chk("R8 mask2", mask2_o,   m_reg[7]);
  endtask

  task automatic bus(input bit en_n, input bit cd, input bit wr_n, input logic [15:0] d);
    bit cw, cr, dw, dr, e_oe, e_ins, e_mw, e_mr, lo_rd, dsi;
    logic [15:0] e_dat;
    string tag;
    @(negedge clk_i);
    chk_regs();
    en_ni = en_n; cd_i = cd; wr_ni = wr_n; data_i = d;
    status_i = $urandom; nfa_i = 16'($urandom); mem_rdata_i = 16'($urandom);
    #1;
    cw = !en_n && !cd && !wr_n; cr = !en_n && !cd && wr_n;
    dw = !en_n && cd && !wr_n;  dr = !en_n && cd && wr_n;
    dsi   = (d[10:8] == 3'd1) && (d[2:0] == 3'd4);
    e_oe  = (cr || dr) && rd_ok();
    e_ins = cw && !m_tco && !m_addr && (wr_ok() || dsi);
    e_mw  = dw && wr_ok() && m_pd == 2'd3;
    e_mr  = dr && rd_ok() && m_ps == 2'd3;
    e_dat = '0; tag = "R13";
    if (cr) begin
      if (m_tco) begin
        case (m_tgt)
          3'd5: begin e_dat = nfa_i; tag = "R5"; end
          3'd6: begin e_dat = m_psi; tag = "R10"; end
          3'd7: begin e_dat = m_pdi; tag = "R10"; end
          default: begin e_dat = m_reg[m_tgt]; tag = "R4"; end
        endcase
      end else begin
        e_dat = m_hi ? status_i[31:16] : status_i[15:0]; tag = "R6";
      end
    end else if (dr) begin
      e_dat = (m_ps == 2'd3) ? mem_rdata_i : m_reg[5 + m_ps]; tag = "R7 R9";
    end
    if (en_n)                                chk("R1 oe", {15'b0, data_oe_o}, 16'(e_oe));
    else if (m_reg[4] == 16'hFFFF && !rd_ok()) chk("R12 oe", {15'b0, data_oe_o}, 16'(e_oe));
    else if (!rd_ok())                       chk("R11 oe", {15'b0, data_oe_o}, 16'(e_oe));
    else                                     chk("R13 oe", {15'b0, data_oe_o}, 16'(e_oe));
    if (e_oe) chk(tag, data_o, e_dat);
    chk(m_addr ? "R3 stb" : (m_tco ? "R4 stb" : "R2 stb"), {15'b0, instr_stb_o}, 16'(e_ins));
    chk("R8 mem_wr", {15'b0, mem_wr_o}, 16'(e_mw));
    chk("R9 mem_rd", {15'b0, mem_rd_o}, 16'(e_mr));
    // advance the reference to the state after the rising edge
    lo_rd = cr && rd_ok() && !m_tco && !m_hi;
    if (cw && m_tco && m_tgt <= 3'd4 && (wr_ok() || m_tgt == 3'd4)) m_reg[m_tgt] = d;
    if (cw && !m_tco && m_addr && wr_ok()) m_reg[0] = d;
    if (dw && wr_ok() && m_pd != 2'd3) m_reg[5 + m_pd] = d;
    m_hi = lo_rd;
    m_addr = e_ins && d[11] && d[10:8] != 3'd1;
    if (e_ins && d[10:8] == 3'd1) begin m_tco = 1; m_tgt = d[2:0]; end
    else if (cw || cr) m_tco = 0;
    if (e_ins && d[10:8] == 3'd2) begin m_ps = d[1:0]; m_psi = d; end
    if (e_ins && d[10:8] == 3'd3) begin m_pd = d[1:0]; m_pdi = d; end
  endtask

  task automatic cwr(input logic [15:0] d); bus(0, 0, 0, d); endtask
  task automatic crd();                     bus(0, 0, 1, '0); endtask
  task automatic dwr(input logic [15:0] d); bus(0, 1, 0, d); endtask
  task automatic drd();                     bus(0, 1, 1, '0); endtask

  initial begin
    void'($urandom(32'h5eed_1480));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state and status halves (R6), incl. break by a data cycle
    crd(); crd(); crd(); crd(); drd(); crd(); crd();
    // R3 address flag, then flag lapse after an idle cycle
    cwr(16'h0800); cwr(16'h1234);
    cwr(16'h0800); bus(1, 0, 0, 16'h0); cwr(16'h0000);
    // R4 one-shot across data cycles
    cwr(16'h0101); dwr(16'h5555); cwr(16'hC0DE); cwr(16'h0000);
    cwr(16'h0101); crd(); crd();
    // R5 next-free-address
    cwr(16'h0105); cwr(16'hBEEF); cwr(16'h0105); crd();
    // R7 R8 R9 R10 persistent selections
    dwr(16'h1111); drd();
    cwr(16'h0301); dwr(16'hAAAA); cwr(16'h0202); drd();
    cwr(16'h0303); dwr(16'h7777); cwr(16'h0203); drd();
    cwr(16'h0107); crd(); cwr(16'h0106); crd();
    // R11 deselect, R12 broadcast
    cwr(16'h0104); cwr(16'h0009); dwr(16'h2222); crd(); cwr(16'h0300);
    cwr(16'h0104); cwr(16'hFFFF); cwr(16'h0300); dwr(16'h3333); drd(); crd();
    cwr(16'h0104); cwr(16'h0000);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 100;
      logic [15:0] d;
      if (!wr_ok() && !m_tco && !m_addr && r < 30) begin
        cwr(16'h0104);
      end else if (m_tco && m_tgt == 3'd4 && r < 60) begin
        cwr((r < 40) ? m_reg[2] : 16'hFFFF);
      end else if (r < 8) begin
        bus(1, 1'($urandom), 1'($urandom), 16'($urandom));
      end else if (r < 45) begin
        if (m_tco && (m_tgt == 3'd2 || m_tgt == 3'd4)) d = 16'($urandom % 4);
        else if (m_tco || m_addr) d = 16'($urandom);
        else d = {4'($urandom), 1'($urandom % 4 == 0), 3'($urandom % 4),
                  5'($urandom), 3'($urandom)};
        cwr(d);
      end else if (r < 65) begin
        crd();
      end else if (r < 82) begin
        dwr(16'($urandom));
      end else begin
        drd();
      end
    end
    @(negedge clk_i);
    chk_regs();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule